// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block sits on the device side of a serial flash, behind a byte shifter that has already turned the serial line into whole bytes. The shifter samples on rising clock edges, MSB first, which covers SPI clock modes 0 and 3. Each byte reaches this decoder as a one-cycle `byte_valid` pulse, and the frame is bounded by the active-low select `cs_n`. The decoder classifies the first byte of a frame as a command. It then gathers the three address bytes, counts off the don't-care bytes the command needs, and raises `cmd_go` for one cycle. That pulse tells the data-phase logic to start. While `cmd_go` is high the command code, page number, column and buffer choice are valid.

The split of the 24-bit address depends on the `page_1024` configuration input. With it low, a page holds 1056 bytes: the page number is the upper 13 bits and the column is the lower 11 bits. With it high, a page holds 1024 bytes: the top bit is ignored, the page is the next 13 bits and the column is the low 10 bits. The column field also serves as the buffer address for buffer reads.

Chip erase is accepted only as an exact four-byte sequence. An unknown command flags an error, and the decoder ignores the rest of that frame.

Top module: `sflash_frame_decoder`

## Requirements
- R1: While reset is asserted and right after it, `cmd_go` is 0, `frame_err` is 0 and `cmd_code` is 0.
- R2: With `page_1024`=0, `cmd_page` is address bits 23..11 and `cmd_col` is address bits 10..0. The address is the three bytes after the command, first byte most significant.
- R3: With `page_1024`=1, `cmd_page` is address bits 22..10 and `cmd_col` is address bits 9..0 with bit 10 zero. Address bit 23 has no effect.
- R4: Array reads. Command 03h gives code 1 and `cmd_go` the cycle after the third address byte. Command 0Bh gives code 2 after one more don't-care byte. Command D2h gives code 3 after four don't-care bytes. None of these pulses `cmd_go` earlier.
- R5: Buffer reads. D1h and D3h give code 4 with no don't-care byte. D4h and D6h give code 5 after one don't-care byte. D1h and D4h select buffer 0 (`cmd_buf`=0), and D3h and D6h select buffer 1.
- R6: Status read D7h gives code 6 and ID read 9Fh gives code 7. In both cases `cmd_go` comes the cycle after the command byte, and page and column read zero.
- R7: Command 35h gives code 8 and `cmd_go` after three don't-care bytes, with no address bytes.
- R8: Code 9 with `cmd_go` appears only after the bytes C7h, 94h, 80h, 9Ah in that order. Any other byte in positions two to four sets `frame_err` and gives no `cmd_go`.
- R9: Once `cmd_go` has pulsed, further bytes in the same frame produce no `cmd_go` and leave `cmd_page` and `cmd_col` unchanged.
- R10: `cs_n` high at any point ends the frame and clears `frame_err`. The next byte of a new frame is decoded as a command.
- R11: A command byte outside the listed set sets `frame_err` the cycle after it arrives. No `cmd_go` follows in that frame.
- R12: `cmd_go` lasts exactly one cycle and always carries a nonzero `cmd_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low frame select |
| byte_valid | input | 1 | One-cycle pulse marking a received byte |
| byte_data | input | 8 | Received byte |
| page_1024 | input | 1 | 1: 1024-byte pages, 0: 1056-byte pages |
| cmd_go | output | 1 | One-cycle pulse: command decoded, data phase begins |
| cmd_code | output | 4 | Decoded command code (see R4 to R8) |
| cmd_page | output | 13 | Page number |
| cmd_col | output | 11 | Byte column or buffer address |
| cmd_buf | output | 1 | Buffer selected by a buffer read |
| frame_err | output | 1 | Unknown command or broken erase sequence in this frame |

## Verification
A miscounted address or don't-care byte moves `cmd_go` by one byte slot, so the bench checks that the pulse has not come before the last required byte and has come right after it. A state that fails to return on `cs_n` shows on the first byte of the next frame as a missing or wrong command. A field sliced from the wrong bits shows as a wrong page or column the moment `cmd_go` pulses. A decoder stuck in its error state shows as a `frame_err` that stays set once the frame has ended.

// File: rtl/sflash_frame_decoder.sv
module sflash_frame_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        page_1024,
  output logic        cmd_go,
  output logic [3:0]  cmd_code,
  output logic [12:0] cmd_page,
  output logic [10:0] cmd_col,
  output logic        cmd_buf,
  output logic        frame_err
);

  localparam logic [3:0] C_NONE = 4'd0, C_ARD = 4'd1, C_ARDF = 4'd2, C_PRD = 4'd3,
                         C_BRD = 4'd4, C_BRDF = 4'd5, C_STAT = 4'd6, C_ID = 4'd7,
                         C_LOCK = 4'd8, C_ERASE = 4'd9;

  typedef enum logic [2:0] {S_OP, S_ADR, S_DMY, S_ERS, S_RUN, S_DROP} st_t;

  st_t         st;
  logic [1:0]  ac;
  logic [2:0]  dc, dneed;
  logic [23:0] adr;

  logic        d_ok, d_addr, d_buf;
  logic [3:0]  d_code;
  logic [2:0]  d_dmy;
  logic [7:0]  ers_want;

  always_comb begin
    d_ok = 1'b1; d_addr = 1'b1; d_buf = 1'b0; d_dmy = 3'd0; d_code = C_NONE;
    unique case (byte_data)
      8'h03: d_code = C_ARD;
      8'h0B: begin d_code = C_ARDF; d_dmy = 3'd1; end
      8'hD2: begin d_code = C_PRD;  d_dmy = 3'd4; end
      8'hD1: d_code = C_BRD;
      8'hD3: begin d_code = C_BRD; d_buf = 1'b1; end
      8'hD4: begin d_code = C_BRDF; d_dmy = 3'd1; end
      8'hD6: begin d_code = C_BRDF; d_dmy = 3'd1; d_buf = 1'b1; end
      8'hD7: begin d_code = C_STAT; d_addr = 1'b0; end
      8'h9F: begin d_code = C_ID;   d_addr = 1'b0; end
      8'h35: begin d_code = C_LOCK; d_addr = 1'b0; d_dmy = 3'd3; end
      default: begin d_ok = 1'b0; d_addr = 1'b0; end
    endcase
  end

  always_comb
    case (ac)
      2'd1:    ers_want = 8'h94;
      2'd2:    ers_want = 8'h80;
      default: ers_want = 8'h9A;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OP; ac <= '0; dc <= '0; dneed <= '0; adr <= '0;
      cmd_go <= 1'b0; cmd_code <= C_NONE; cmd_buf <= 1'b0; frame_err <= 1'b0;
    end else begin
      cmd_go <= 1'b0;
      if (cs_n) begin
        st <= S_OP; ac <= '0; frame_err <= 1'b0; cmd_code <= C_NONE;
      end else if (byte_valid) begin
        case (st)
          S_OP: begin
            adr <= '0;
            if (byte_data == 8'hC7) begin
              st <= S_ERS; ac <= 2'd1;
            end else if (!d_ok) begin
              frame_err <= 1'b1; st <= S_DROP;
            end else begin
              cmd_code <= d_code; cmd_buf <= d_buf; dneed <= d_dmy;
              if (d_addr) begin
                st <= S_ADR; ac <= 2'd0;
              end else if (d_dmy != 3'd0) begin
                st <= S_DMY; dc <= d_dmy;
              end else begin
                st <= S_RUN; cmd_go <= 1'b1;
              end
            end
          end
          S_ADR: begin
            adr <= {adr[15:0], byte_data};
            ac  <= ac + 2'd1;
            if (ac == 2'd2) begin
              if (dneed != 3'd0) begin
                st <= S_DMY; dc <= dneed;
              end else begin
                st <= S_RUN; cmd_go <= 1'b1;
              end
            end
          end
          S_DMY: begin
            dc <= dc - 3'd1;
            if (dc == 3'd1) begin
              st <= S_RUN; cmd_go <= 1'b1;
            end
          end
          S_ERS: begin
            if (byte_data != ers_want) begin
              frame_err <= 1'b1; st <= S_DROP;
            end else if (ac == 2'd3) begin
              cmd_code <= C_ERASE; cmd_go <= 1'b1; st <= S_RUN;
            end else begin
              ac <= ac + 2'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd_page = page_1024 ? adr[22:10] : adr[23:11];
  assign cmd_col  = page_1024 ? {1'b0, adr[9:0]} : adr[10:0];

  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_go |=> !cmd_go);  // R12
  AST_GO_HAS_CODE:  assert property (@(posedge clk) disable iff (!rst_n) cmd_go |-> cmd_code != C_NONE);  // R12
  AST_GO_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) cmd_go |-> ($past(byte_valid) && !$past(cs_n)));  // R4
  AST_ERASE_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_go && cmd_code == C_ERASE) |-> $past(byte_data) == 8'h9A);  // R8
  AST_ERR_BLOCKS_GO: assert property (@(posedge clk) disable iff (!rst_n) (frame_err && !cs_n) |=> !cmd_go);  // R11
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> (st == S_OP && !frame_err));  // R10
  AST_RUN_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (st == S_RUN && !cs_n) |=> $stable(adr));  // R9

endmodule

// File: tb/sflash_frame_decoder_tb.sv
module sflash_frame_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, byte_valid = 1'b0, page_1024 = 1'b0;
  logic [7:0] byte_data = '0;
  logic cmd_go, cmd_buf, frame_err;
  logic [3:0] cmd_code;
  logic [12:0] cmd_page;
  logic [10:0] cmd_col;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0]  code;
    logic [12:0] page;
    logic [10:0] col;
    logic        bufid;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  sflash_frame_decoder u_dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cmd_go) begin
    if (q.size() == 0) chk(1'b0, "R9 unexpected cmd_go", 1, 0);
    else begin
      e = q.pop_front();
      chk(cmd_code == e.code, e.tag, cmd_code, e.code);
      chk(cmd_page == e.page, e.tag, cmd_page, e.page);
      chk(cmd_col  == e.col,  e.tag, cmd_col,  e.col);
      chk(cmd_buf  == e.bufid, e.tag, cmd_buf, e.bufid);
    end
  end

  task automatic push(input logic [3:0] c, input logic [23:0] a, input bit has_a,
                      input logic b, input string tag);
    exp_t x;
    x.code = c; x.bufid = b; x.tag = tag;
    if (!has_a) begin x.page = '0; x.col = '0; end
    else if (page_1024) begin x.page = a[22:10]; x.col = {1'b0, a[9:0]}; end
    else begin x.page = a[23:11]; x.col = a[10:0]; end
    q.push_back(x);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_data = b; byte_valid = 1'b1;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic open_f;  @(negedge clk); cs_n = 1'b0; endtask
  task automatic close_f; @(negedge clk); cs_n = 1'b1; @(negedge clk); endtask

  // one frame: opcode, optional 3 address bytes, ndmy don't-care bytes
  task automatic frame(input logic [7:0] op, input logic [23:0] a, input bit has_a, input int ndmy,
                       input logic [3:0] c, input logic b, input string tag);
    push(c, a, has_a, b, tag);
    open_f();
    if (has_a || ndmy > 0) begin
      send(op);
      if (has_a) begin
        send(a[23:16]); send(a[15:8]);
        if (ndmy > 0) send(a[7:0]);
      end
      for (int i = 0; i < ndmy - 1; i++) send(8'h5C);
      @(negedge clk);
      chk(q.size() == 1, {tag, " no early go"}, q.size(), 1);
      if (has_a && ndmy == 0) send(a[7:0]); else send(8'h5C);
    end else send(op);
    @(negedge clk);
    chk(q.size() == 0, {tag, " go after last byte"}, q.size(), 0);
    close_f();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_go == 0 && frame_err == 0 && cmd_code == 0, "R1 reset outputs",
        {cmd_go, frame_err, cmd_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_go == 0 && frame_err == 0 && cmd_code == 0, "R1 after reset", {cmd_go, frame_err, cmd_code}, 0);

    frame(8'h03, 24'hABCDEF, 1, 0, 4'd1, 0, "R2 R4 03h 1056");
    frame(8'h0B, 24'h123456, 1, 1, 4'd2, 0, "R2 R4 0Bh 1056");
    frame(8'hD2, 24'hFFF7FF, 1, 4, 4'd3, 0, "R2 R4 D2h 1056");
    frame(8'hD1, 24'h0007A5, 1, 0, 4'd4, 0, "R5 D1h");
    frame(8'hD3, 24'h000412, 1, 0, 4'd4, 1, "R5 D3h");
    frame(8'hD4, 24'h0002FF, 1, 1, 4'd5, 0, "R5 D4h");
    frame(8'hD6, 24'h0007FF, 1, 1, 4'd5, 1, "R5 D6h");
    frame(8'hD7, 24'h0, 0, 0, 4'd6, 0, "R6 D7h");
    frame(8'h9F, 24'h0, 0, 0, 4'd7, 0, "R6 9Fh");
    frame(8'h35, 24'h0, 0, 3, 4'd8, 0, "R7 35h");

    page_1024 = 1'b1;
    frame(8'h03, 24'hABCDEF, 1, 0, 4'd1, 0, "R3 03h 1024");
    frame(8'h03, 24'h2BCDEF, 1, 0, 4'd1, 0, "R3 bit23 ignored");
    frame(8'hD2, 24'h7FFFFF, 1, 4, 4'd3, 0, "R3 D2h 1024");
    frame(8'hD4, 24'h0003FF, 1, 1, 4'd5, 0, "R3 R5 buffer 1024");

    // R8 full erase sequence, then trailing bytes ignored (R9)
    push(4'd9, 24'h0, 0, 0, "R8 chip erase");
    open_f(); send(8'hC7); send(8'h94); send(8'h80);
    @(negedge clk); chk(q.size() == 1, "R8 no early erase", q.size(), 1);
    send(8'h9A); @(negedge clk);
    chk(q.size() == 0, "R8 erase go", q.size(), 0);
    send(8'h03); send(8'hD7); send(8'h00);
    @(negedge clk); chk(frame_err == 0, "R9 trailing bytes no error", frame_err, 0);
    close_f();

    // R9 page held after a read started
    push(4'd1, 24'h456789, 1, 0, "R9 read");
    open_f(); send(8'h03); send(8'h45); send(8'h67); send(8'h89);
    send(8'hFF); send(8'hD7); send(8'h12); @(negedge clk);
    chk(cmd_page == 13'h1159 && cmd_col == 11'h389, "R9 fields stable", {cmd_page, cmd_col},
        {13'h1159, 11'h389});
    close_f();

    // R8 broken erase
    open_f(); send(8'hC7); send(8'h94); send(8'h81); @(negedge clk);
    chk(frame_err == 1, "R8 bad erase byte", frame_err, 1);
    send(8'h9A); send(8'hD7); close_f();
    chk(frame_err == 0, "R10 error cleared", frame_err, 0);

    // R8 erase cut short by cs_n, then R10 next frame decodes
    open_f(); send(8'hC7); send(8'h94); send(8'h80); close_f();
    frame(8'hD7, 24'h0, 0, 0, 4'd6, 0, "R10 after cut erase");

    // R10 abort mid address
    open_f(); send(8'h0B); send(8'h11); close_f();
    frame(8'h9F, 24'h0, 0, 0, 4'd7, 0, "R10 after abort");

    // R11 unknown opcode
    open_f(); send(8'h5A); @(negedge clk);
    chk(frame_err == 1, "R11 unknown sets error", frame_err, 1);
    send(8'hD7); send(8'h9F); @(negedge clk);
    chk(frame_err == 1, "R11 rest ignored", frame_err, 1);
    close_f();
    chk(frame_err == 0, "R10 error cleared at frame end", frame_err, 0);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R12 all commands seen", q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule